// File: doc/BRIEF.md
# Hybrid Branch Direction and Target Predictor

This block gives a direction and a target for one branch per cycle. The front end presents the branch's linear address, its class, the signed displacement known at decode, and its fall-through address. In the same cycle the block answers with a taken flag, a predicted target and a code that names the mechanism behind the answer. No register lies between the request and the answer.

Three mechanisms supply the prediction. The first is a direct-mapped target table, indexed and tagged by the branch address, where each entry carries a two-bit saturating counter. The second is a sign-of-displacement rule that covers direct conditional branches the table does not hold. The third is a sixteen-deep return stack for returns. Far transfers get no prediction. A separate resolution port trains the table with the actual outcome of each branch.

Top module: `hybrid_bpred`

## Requirements
- R1: A request with `lk_class` = 0 (direct conditional) that hits a valid table entry with a matching tag predicts taken exactly when the entry's counter is 2 or 3. When taken, the target is the stored target. `pred_src` = 1 (table).
- R2: A direct conditional request that misses the table uses the static rule, and `pred_src` = 2. A negative displacement (bit DISP_W-1 set) predicts taken, with target = fall-through + sign-extended displacement. A zero or positive displacement predicts not taken.
- R3: Whenever `pred_taken` is 0, `pred_target` equals `lk_fallthru`.
- R4: A request of class 1 (call) pushes its fall-through address onto the return stack. A request of class 2 (return) predicts taken with `pred_src` = 3 and takes the most recently pushed, unpopped address as its target.
- R5: The return stack holds 16 entries. A push onto a full stack overwrites the oldest entry, so the following 16 pops return the 16 newest pushes, newest first.
- R6: A return on an empty stack raises `ras_underflow` and predicts the value popped last (0 after reset). It leaves the stack empty.
- R7: Classes 4 (far call), 5 (interrupt return), 6 (software interrupt) and 7 (reserved) predict not taken with `pred_src` = 0. They neither push nor pop the stack.
- R8: A call (1) or indirect branch (3) that misses the table predicts not taken with `pred_src` = 0. On a hit it follows the table as in R1.
- R9: A resolution (`rs_valid`) of a taken branch that misses the table allocates an entry holding the resolved target, with its counter at 2 (weakly taken).
- R10: A resolution that hits moves the counter up by one when taken and down by one when not taken, saturating at 0 and 3. It replaces the stored target only when taken.
- R11: A not-taken resolution that misses the table changes nothing.
- R12: The table index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. Two addresses that share an index but differ in tag do not hit each other's entry.
- R13: With `lk_valid` low, or after reset with an empty table and stack, the block predicts not taken with `pred_src` = 0. Predictions are combinational in the request cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Prediction request present |
| lk_pc | input | ADDR_W | Linear address of the branch |
| lk_class | input | 3 | Branch class code (0 cond, 1 call, 2 return, 3 indirect, 4-7 far/none) |
| lk_disp | input | DISP_W | Signed decode-time displacement |
| lk_fallthru | input | ADDR_W | Address of the next sequential instruction |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | ADDR_W | Predicted next address |
| pred_src | output | 2 | Source: 0 none, 1 table, 2 static, 3 stack |
| ras_underflow | output | 1 | Return popped an empty stack |
| rs_valid | input | 1 | Resolution present |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | ADDR_W | Actual target |

## Verification
The hardest state to reach is a stack that has wrapped. The write pointer must pass the oldest slot and overwrite it, and the pops must then run through the whole ring back to an empty stack that replays its last value. The stimulus pushes twenty calls in a row. It then pops sixteen times and once more. Each result is compared with an address computed from the push number. Counter saturation at both ends is reached by repeated resolutions of one address, with the direction checked after each step.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [2:0] {
        BR_COND    = 3'd0,
        BR_CALL    = 3'd1,
        BR_RET     = 3'd2,
        BR_IND     = 3'd3,
        BR_FARCALL = 3'd4,
        BR_IRET    = 3'd5,
        BR_SWINT   = 3'd6,
        BR_RSVD    = 3'd7
    } br_class_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_TABLE  = 2'd1,
        SRC_STATIC = 2'd2,
        SRC_STACK  = 2'd3
    } pred_src_e;

    localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              hit,
    output logic              hit_taken,
    output logic [ADDR_W-1:0] hit_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        logic [1:0]        ctr;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } st_t;

    st_t s_q, s_d;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    ent_t             rd_ent, up_ent;
    logic             up_hit;

    assign lk_idx = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[ADDR_W-1:IDX_W];
    assign up_idx = up_pc[IDX_W-1:0];
    assign up_tag = up_pc[ADDR_W-1:IDX_W];

    // lookup reads the registered state only
    always_comb begin
        rd_ent     = s_q.ent[lk_idx];
        hit        = rd_ent.vld && (rd_ent.tag == lk_tag);
        hit_taken  = rd_ent.ctr[1];
        hit_target = rd_ent.tgt;
    end

    always_comb begin
        s_d    = s_q;
        up_ent = s_q.ent[up_idx];
        up_hit = up_ent.vld && (up_ent.tag == up_tag);
        if (up_valid) begin
            if (up_hit) begin
                up_ent.ctr = ctr_step(up_ent.ctr, up_taken);
                if (up_taken)
                    up_ent.tgt = up_target;
                s_d.ent[up_idx] = up_ent;
            end else if (up_taken) begin
                up_ent.vld = 1'b1;
                up_ent.tag = up_tag;
                up_ent.tgt = up_target;
                up_ent.ctr = CTR_WEAK_TAKEN;
                s_d.ent[up_idx] = up_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_val,
    input  logic              pop,
    output logic [ADDR_W-1:0] top_val,
    output logic              underflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PTR_W-1:0]             ptr;
        logic [CNT_W-1:0]             cnt;
        logic [ADDR_W-1:0]            last;
    } st_t;

    st_t s_q, s_d;

    logic [PTR_W-1:0] ptr_prev, ptr_next;
    logic             empty;

    always_comb begin
        ptr_prev  = (s_q.ptr == PTR_W'(0))         ? PTR_W'(DEPTH - 1) : s_q.ptr - 1'b1;
        ptr_next  = (s_q.ptr == PTR_W'(DEPTH - 1)) ? PTR_W'(0)         : s_q.ptr + 1'b1;
        empty     = (s_q.cnt == '0);
        top_val   = empty ? s_q.last : s_q.mem[ptr_prev];
        underflow = pop && empty;

        s_d = s_q;
        if (push) begin
            // when full, ptr already points at the oldest slot
            s_d.mem[s_q.ptr] = push_val;
            s_d.ptr          = ptr_next;
            if (s_q.cnt != CNT_W'(DEPTH))
                s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            s_d.ptr  = ptr_prev;
            s_d.cnt  = s_q.cnt - 1'b1;
            s_d.last = s_q.mem[ptr_prev];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bpred_static.sv
module bpred_static #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] fallthru,
    output logic              backward,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        backward = disp[DISP_W-1];
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        target   = fallthru + disp_ext;
    end

endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred
    import bpred_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DISP_W    = 16,
    parameter int IDX_W     = 4,
    parameter int RAS_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [2:0]        lk_class,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic [ADDR_W-1:0] lk_fallthru,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [1:0]        pred_src,
    output logic              ras_underflow,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target
);
    br_class_e         cls;
    logic              tb_hit, tb_taken;
    logic [ADDR_W-1:0] tb_target;
    logic              st_back;
    logic [ADDR_W-1:0] st_target;
    logic              rs_push, rs_pop;
    logic [ADDR_W-1:0] rs_top;
    pred_src_e         src;

    assign cls     = br_class_e'(lk_class);
    assign rs_push = lk_valid && (cls == BR_CALL);
    assign rs_pop  = lk_valid && (cls == BR_RET);

    bpred_btb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_btb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (lk_pc),
        .hit        (tb_hit),
        .hit_taken  (tb_taken),
        .hit_target (tb_target),
        .up_valid   (rs_valid),
        .up_pc      (rs_pc),
        .up_taken   (rs_taken),
        .up_target  (rs_target)
    );

    bpred_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rs_push),
        .push_val  (lk_fallthru),
        .pop       (rs_pop),
        .top_val   (rs_top),
        .underflow (ras_underflow)
    );

    bpred_static #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_static (
        .disp     (lk_disp),
        .fallthru (lk_fallthru),
        .backward (st_back),
        .target   (st_target)
    );

    always_comb begin
        pred_taken  = 1'b0;
        pred_target = lk_fallthru;
        src         = SRC_NONE;
        if (lk_valid) begin
            unique case (cls)
                BR_COND: begin
                    if (tb_hit) begin
                        src        = SRC_TABLE;
                        pred_taken = tb_taken;
                        if (tb_taken) pred_target = tb_target;
                    end else begin
                        src        = SRC_STATIC;
                        pred_taken = st_back;
                        if (st_back) pred_target = st_target;
                    end
                end
                BR_CALL, BR_IND: begin
                    if (tb_hit) begin
                        src        = SRC_TABLE;
                        pred_taken = tb_taken;
                        if (tb_taken) pred_target = tb_target;
                    end
                end
                BR_RET: begin
                    src         = SRC_STACK;
                    pred_taken  = 1'b1;
                    pred_target = rs_top;
                end
                default: ;
            endcase
        end
        pred_src = src;
    end

endmodule

// File: rtl/hybrid_bpred_chk.sv
module hybrid_bpred_chk #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [2:0]        lk_class,
    input logic [DISP_W-1:0] lk_disp,
    input logic [ADDR_W-1:0] lk_fallthru,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic [1:0]        pred_src,
    input logic              ras_underflow
);
    a_r2_static_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_class == 3'd0 && pred_src == 2'd2) |-> (pred_taken == lk_disp[DISP_W-1]));

    a_r3_fallthru_when_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_target == lk_fallthru));

    a_r4_call_then_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_class == 3'd1) |=>
        ((lk_valid && lk_class == 3'd2) -> (pred_target == $past(lk_fallthru))));

    a_r4_ret_from_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_class == 3'd2) |-> (pred_taken && pred_src == 2'd3));

    a_r6_underflow_on_ret: assert property (@(posedge clk) disable iff (!rst_n)
        ras_underflow |-> (lk_valid && lk_class == 3'd2));

    a_r7_far_unpredicted: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_class[2]) |-> (!pred_taken && pred_src == 2'd0));

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!pred_taken && pred_src == 2'd0 && !ras_underflow));

endmodule

bind hybrid_bpred hybrid_bpred_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_class      (lk_class),
    .lk_disp       (lk_disp),
    .lk_fallthru   (lk_fallthru),
    .pred_taken    (pred_taken),
    .pred_target   (pred_target),
    .pred_src      (pred_src),
    .ras_underflow (ras_underflow)
);

// File: tb/hybrid_bpred_bench.sv
module hybrid_bpred_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [2:0]  lk_class = '0;
    logic [15:0] lk_disp = '0;
    logic [31:0] lk_fallthru = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic [1:0]  pred_src;
    logic        ras_underflow;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;

    int errors = 0;
    int checks = 0;
    logic        o_tk, o_uf;
    logic [31:0] o_tg;
    logic [1:0]  o_src;

    always #4 clk = ~clk;

    hybrid_bpred u_hybrid_bpred (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_class(lk_class), .lk_disp(lk_disp), .lk_fallthru(lk_fallthru),
        .pred_taken(pred_taken), .pred_target(pred_target), .pred_src(pred_src),
        .ras_underflow(ras_underflow), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_taken(rs_taken), .rs_target(rs_target)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [2:0] cls,
                        input logic [15:0] d, input logic [31:0] ft);
        @(negedge clk);
        lk_pc = pc; lk_class = cls; lk_disp = d; lk_fallthru = ft; lk_valid = 1'b1;
        #1;
        o_tk = pred_taken; o_tg = pred_target; o_src = pred_src; o_uf = ras_underflow;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        @(negedge clk);
        rs_pc = pc; rs_taken = tk; rs_target = tg; rs_valid = 1'b1;
        @(posedge clk);
        #1 rs_valid = 1'b0;
    endtask

    task automatic expect_pred(input string req, input logic tk, input logic [31:0] tg,
                               input logic [1:0] src, input logic uf);
        chk({req, " taken"}, {31'd0, o_tk}, {31'd0, tk});
        chk({req, " target"}, o_tg, tg);
        chk({req, " source"}, {30'd0, o_src}, {30'd0, src});
        chk({req, " underflow"}, {31'd0, o_uf}, {31'd0, uf});
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] dv;
        logic [31:0] ft, exp_t, pc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13: idle and reset state
        @(negedge clk);
        lk_fallthru = 32'h0000_1234;
        #1;
        o_tk = pred_taken; o_tg = pred_target; o_src = pred_src; o_uf = ras_underflow;
        expect_pred("R13 idle", 1'b0, 32'h0000_1234, 2'd0, 1'b0);

        // R6: empty stack after reset replays 0
        look(32'h200, 3'd2, 16'd0, 32'h204);
        expect_pred("R6 empty pop", 1'b1, 32'h0, 2'd3, 1'b1);

        // R7/R8: call miss, far classes leave stack untouched
        look(32'h100, 3'd1, 16'd0, 32'h104);
        expect_pred("R8 call miss", 1'b0, 32'h104, 2'd0, 1'b0);
        for (int c = 4; c < 8; c++) begin
            look(32'h110 + c, 3'(c), 16'hFFF0, 32'h200 + c);
            expect_pred("R7 far class", 1'b0, 32'h200 + c, 2'd0, 1'b0);
        end
        look(32'h300, 3'd2, 16'd0, 32'h304);
        expect_pred("R4 R7 ret after far", 1'b1, 32'h104, 2'd3, 1'b0);

        // R2/R3: static sweep across indices and displacements
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 6; j++) begin
                case (j)
                    0: dv = 16'h8000;
                    1: dv = 16'hFFFF;
                    2: dv = 16'h0000;
                    3: dv = 16'h0001;
                    4: dv = 16'h7FFF;
                    default: dv = 16'(i * 1237 - 9000);
                endcase
                pc = 32'h4000_0000 + i;
                ft = pc + 32'd2 + j;
                exp_t = dv[15] ? ft + {{16{dv[15]}}, dv} : ft;
                look(pc, 3'd0, dv, ft);
                expect_pred("R2 R3 static", dv[15], exp_t, 2'd2, 1'b0);
            end
        end

        // R5/R6: wrap the return stack
        for (int i = 0; i < 20; i++)
            look(32'h5000 + i, 3'd1, 16'd0, 32'h0010_0000 + i * 8);
        for (int k = 0; k < 16; k++) begin
            look(32'h6000 + k, 3'd2, 16'd0, 32'h0);
            expect_pred("R5 wrap pop", 1'b1, 32'h0010_0000 + (19 - k) * 8, 2'd3, 1'b0);
        end
        look(32'h6100, 3'd2, 16'd0, 32'h0);
        expect_pred("R6 underflow replay", 1'b1, 32'h0010_0000 + 4 * 8, 2'd3, 1'b1);

        // R9/R10: allocate, train and saturate one entry
        resolve(32'h8003, 1'b1, 32'h9000);
        look(32'h8003, 3'd0, 16'h0010, 32'h8005);
        expect_pred("R9 R1 alloc weak taken", 1'b1, 32'h9000, 2'd1, 1'b0);
        resolve(32'h8003, 1'b0, 32'h0);
        look(32'h8003, 3'd0, 16'hFFF0, 32'h8005);
        expect_pred("R10 R3 down to 1", 1'b0, 32'h8005, 2'd1, 1'b0);
        resolve(32'h8003, 1'b0, 32'h0);
        resolve(32'h8003, 1'b0, 32'h0);
        resolve(32'h8003, 1'b1, 32'hA000);
        look(32'h8003, 3'd0, 16'h0010, 32'h8005);
        expect_pred("R10 low saturation", 1'b0, 32'h8005, 2'd1, 1'b0);
        resolve(32'h8003, 1'b1, 32'hA000);
        look(32'h8003, 3'd0, 16'h0010, 32'h8005);
        expect_pred("R10 target refresh", 1'b1, 32'hA000, 2'd1, 1'b0);
        resolve(32'h8003, 1'b1, 32'hB000);
        resolve(32'h8003, 1'b1, 32'hB000);
        resolve(32'h8003, 1'b0, 32'hC000);
        look(32'h8003, 3'd0, 16'h0010, 32'h8005);
        expect_pred("R10 high saturation", 1'b1, 32'hB000, 2'd1, 1'b0);

        // R12: alias on same index, different tag
        look(32'h8013, 3'd0, 16'hFFFC, 32'h8015);
        expect_pred("R12 alias miss", 1'b1, 32'h8011, 2'd2, 1'b0);

        // R11: not-taken miss does not allocate
        resolve(32'h8005, 1'b0, 32'hD000);
        look(32'h8005, 3'd0, 16'h0004, 32'h8007);
        expect_pred("R11 no alloc fwd", 1'b0, 32'h8007, 2'd2, 1'b0);
        look(32'h8005, 3'd0, 16'hFFFC, 32'h8007);
        expect_pred("R11 no alloc back", 1'b1, 32'h8003, 2'd2, 1'b0);

        // R1/R9/R12: fill every index, then hit each
        for (int i = 0; i < 16; i++)
            resolve(32'h0002_0000 + i, 1'b1, 32'h7000_0000 + i * 64);
        for (int i = 0; i < 16; i++) begin
            look(32'h0002_0000 + i, 3'd0, 16'h0001, 32'h0002_0100);
            expect_pred("R1 full table cond", 1'b1, 32'h7000_0000 + i * 64, 2'd1, 1'b0);
            look(32'h0002_0000 + i, 3'd3, 16'h0000, 32'h0002_0100);
            expect_pred("R8 full table indirect", 1'b1, 32'h7000_0000 + i * 64, 2'd1, 1'b0);
        end

        // R8: indirect miss, then trained hits for indirect and call
        look(32'h5551, 3'd3, 16'hFF00, 32'h5553);
        expect_pred("R8 indirect miss", 1'b0, 32'h5553, 2'd0, 1'b0);
        resolve(32'h5551, 1'b1, 32'hABC0);
        look(32'h5551, 3'd3, 16'h0000, 32'h5553);
        expect_pred("R8 indirect hit", 1'b1, 32'hABC0, 2'd1, 1'b0);
        resolve(32'h5550, 1'b1, 32'h1234_0000);
        look(32'h5550, 3'd1, 16'h0000, 32'h5555);
        expect_pred("R8 call hit", 1'b1, 32'h1234_0000, 2'd1, 1'b0);
        look(32'h7777, 3'd2, 16'h0000, 32'h0);
        expect_pred("R4 ret after call", 1'b1, 32'h5555, 2'd3, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule